// File: doc/BRIEF.md
# Four-Phase Interlocked Request/Acknowledge Word Link

This block carries single-word reads and writes between two clock domains over an unclocked request/acknowledge bus. A master controller accepts a command on a local port: direction, address and write data. It places the address, the direction and the write data on the shared bus lines. It then holds them still for a programmable settling interval so the slave can decode the target, and only after that raises the request. A slave controller, running on its own clock, sees the request through a synchronizer. It checks whether the address falls in its window. It then either stores the write word into a small register file or drives the addressed word back, and raises acknowledge.

Every edge of the two strobes is interlocked. The master lowers request only once it has seen acknowledge high. For a read, it latches the returned word at that same moment. The slave lowers acknowledge only once it has seen request low. The master finishes the transfer and accepts a new command only after it has seen acknowledge low. Only one transfer is ever in flight. While one is open the master reports busy and drops any command it is offered. An address outside the slave window is never acknowledged, so such a transfer never ends.

Master states: IDLE (waits for a command), SETUP (bus lines driven, counting the decode interval), REQ (request high, waiting for acknowledge), REL (request low, waiting for acknowledge to clear). Master transitions: IDLE to SETUP on an accepted command; SETUP to REQ when the count ends; REQ to REL when synchronized acknowledge is high; REL to IDLE when it is low, with a one-cycle done pulse. Slave states: WAIT (acknowledge low) and ACK (acknowledge high). Slave transitions: WAIT to ACK when synchronized request is high and the address hits; ACK to WAIT when synchronized request is low.

Top module: `hs_link`

## Requirements
- R1: After either reset, hs_req, hs_ack, busy and done are 0 and rsp_rdata is 0.
- R2: hs_req rises exactly DECODE_WAIT master clock cycles after busy rises (default 2). Address, direction and write data on the bus stay unchanged while hs_req is high.
- R3: A write stores cmd_wdata into the slave register selected by the low REG_AW address bits. A later read of that address returns it.
- R4: A read returns, on rsp_rdata when done is high, the word held by the addressed slave register. The word is captured as the master observes acknowledge.
- R5: hs_ack rises only while hs_req is high and falls only after hs_req is low. hs_req falls only while hs_ack is high.
- R6: hs_req rises for a new transfer only while hs_ack is low. done pulses for exactly one master cycle after the master observes hs_ack low.
- R7: busy is 1 from the cycle after a command is accepted until done. A command offered while busy is 1 is ignored and changes no slave register.
- R8: The slave acknowledges only addresses whose upper ADDR_W-REG_AW bits equal SLAVE_BASE (default 2'b10, so addresses 8 to 11). For any other address hs_req stays high, hs_ack stays 0 and busy stays 1.
- R9: rsp_rdata changes only when a read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_clk | input | 1 | Master clock |
| m_rst_n | input | 1 | Master asynchronous reset, active low |
| s_clk | input | 1 | Slave clock |
| s_rst_n | input | 1 | Slave asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered (taken only when not busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word returned by the last read |
| hs_req | output | 1 | Bus request strobe (observation) |
| hs_ack | output | 1 | Bus acknowledge strobe (observation) |

## Verification
The strobe assertions take for granted that each side's reset is released while the other side is idle. They also take for granted that commands target only the slave window, so a transfer always ends. The walked vector table and the directed busy-collision test use in-window addresses only. The one out-of-window transfer is the last stimulus, and both resets are asserted afterwards to recover, with the assertions disabled during that reset. The two clocks have unrelated periods, so the synchronizer delays vary from transfer to transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        M_IDLE,
        M_SETUP,
        M_REQ,
        M_REL
    } mst_state_t;

    typedef enum logic {
        S_WAIT,
        S_ACK
    } slv_state_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int DECODE_WAIT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int CNT_W = $clog2(DECODE_WAIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECODE_WAIT - 1);

    mst_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             ack_s;
    logic             done_q;
    logic [DATA_W-1:0] rdata_q;

    hs_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:  if (cmd_valid)       nxt = M_SETUP;
            M_SETUP: if (cnt == CNT_LAST) nxt = M_REQ;
            M_REQ:   if (ack_s)           nxt = M_REL;
            M_REL:   if (!ack_s)          nxt = M_IDLE;
            default:                      nxt = M_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bus_write <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state == M_REL) && !ack_s;
            if (state == M_IDLE && cmd_valid) begin
                bus_write <= cmd_write;
                bus_addr  <= cmd_addr;
                bus_wdata <= cmd_wdata;
                cnt       <= '0;
            end
            if (state == M_SETUP) cnt <= cnt + 1'b1;
            if (state == M_REQ && ack_s && !bus_write) rdata_q <= bus_rdata;
        end
    end

    // outputs
    always_comb begin
        bus_req   = (state == M_REQ);
        busy      = (state != M_IDLE);
        done      = done_q;
        rsp_rdata = rdata_q;
    end

    // R2: bus fields unchanged while request is high
    a_r2_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));
    // R5: request falls only while acknowledge is high on the bus
    a_r5_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> bus_ack);
    // R6: request rises only while acknowledge is low
    a_r6_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !bus_ack);
    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done coincides with the return to idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int REG_AW      = 2,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-REG_AW-1:0] SLAVE_BASE = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int DEPTH = 1 << REG_AW;

    slv_state_t        state, nxt;
    logic              req_s;
    logic              hit;
    logic [REG_AW-1:0] idx;
    logic [DATA_W-1:0] regs [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    hs_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_s)
    );

    assign hit = (bus_addr[ADDR_W-1:REG_AW] == SLAVE_BASE);
    assign idx = bus_addr[REG_AW-1:0];

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT:  if (req_s && hit) nxt = S_ACK;
            S_ACK:   if (!req_s)       nxt = S_WAIT;
            default:                   nxt = S_WAIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_WAIT;
        else        state <= nxt;
    end

    // register file and read word
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (state == S_WAIT && req_s && hit && bus_write && idx == REG_AW'(g))
                    regs[g] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state == S_WAIT && req_s && hit && !bus_write)
            rdata_q <= regs[idx];
    end

    // outputs
    always_comb begin
        bus_ack   = (state == S_ACK);
        bus_rdata = rdata_q;
    end

    // R5: acknowledge rises only while request is high
    a_r5_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> bus_req);
    // R5: acknowledge falls only after request is low
    a_r5_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ack) |-> !bus_req);
    // R4: read word held steady while acknowledge is high
    a_r4_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_rdata));
endmodule

// File: rtl/hs_link.sv
module hs_link #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int REG_AW      = 2,
    parameter int DECODE_WAIT = 2,
    parameter int SYNC_STAGES = 2,
    parameter logic [ADDR_W-REG_AW-1:0] SLAVE_BASE = 2'b10
) (
    input  logic              m_clk,
    input  logic              m_rst_n,
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              hs_req,
    output logic              hs_ack
);
    logic              b_write;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata;
    logic [DATA_W-1:0] b_rdata;

    hs_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DECODE_WAIT(DECODE_WAIT), .SYNC_STAGES(SYNC_STAGES)
    ) i_master (
        .clk(m_clk), .rst_n(m_rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .bus_req(hs_req), .bus_write(b_write), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_ack(hs_ack), .bus_rdata(b_rdata)
    );

    hs_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW),
        .SYNC_STAGES(SYNC_STAGES), .SLAVE_BASE(SLAVE_BASE)
    ) i_slave (
        .clk(s_clk), .rst_n(s_rst_n),
        .bus_req(hs_req), .bus_write(b_write), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_ack(hs_ack), .bus_rdata(b_rdata)
    );
endmodule

// File: tb/test_hs_link.sv
`timescale 1ns/1ps
module test_hs_link;
    localparam int DW = 2;

    logic       m_clk = 1'b0, s_clk = 1'b0;
    logic       m_rst_n = 1'b0, s_rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_write = 1'b0;
    logic [3:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       busy, done, hs_req, hs_ack;
    logic [7:0] rsp_rdata;

    int checks = 0, errors = 0, interlock_bad = 0;

    always #2.5 m_clk = ~m_clk;   // 200 MHz master
    always #3.5 s_clk = ~s_clk;   // unrelated slave clock

    hs_link i_hs_link (
        .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
        .hs_req(hs_req), .hs_ack(hs_ack)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 4'h8, 8'h3C, 8'h00},
        '{1'b1, 4'h9, 8'hA5, 8'h00},
        '{1'b1, 4'hA, 8'h0F, 8'h00},
        '{1'b1, 4'hB, 8'hF0, 8'h00},
        '{1'b0, 4'hB, 8'h00, 8'hF0},
        '{1'b0, 4'h8, 8'h00, 8'h3C},
        '{1'b1, 4'h9, 8'h77, 8'h3C},
        '{1'b0, 4'h9, 8'h00, 8'h77},
        '{1'b0, 4'hA, 8'h00, 8'h0F}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5 R6 interlock monitor on the raw strobes
    logic prev_req = 1'b0, prev_ack = 1'b0;
    always @(hs_req or hs_ack) begin
        if (m_rst_n && s_rst_n) begin
            if (hs_req && !prev_req && hs_ack) interlock_bad++;
            if (!hs_req && prev_req && !hs_ack) interlock_bad++;
            if (hs_ack && !prev_ack && !hs_req) interlock_bad++;
            if (!hs_ack && prev_ack && hs_req) interlock_bad++;
        end
        prev_req = hs_req;
        prev_ack = hs_ack;
    end

    task automatic run_cmd(input logic wr, input logic [3:0] addr, input logic [7:0] wd,
                           input logic [7:0] exp, input string tag);
        int n;
        @(negedge m_clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = addr; cmd_wdata = wd;
        @(negedge m_clk);
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R7 busy after accept", busy, 1);
        n = 0;
        while (!hs_req && n < 50) begin
            @(negedge m_clk);
            n++;
        end
        check(n == DW, "R2 decode wait", n, DW);
        n = 0;
        while (!done && n < 400) begin
            @(negedge m_clk);
            n++;
        end
        check(done === 1'b1, "R6 done reached", done, 1);
        check(rsp_rdata === exp, tag, rsp_rdata, exp);
        @(negedge m_clk);
        check(done === 1'b0 && busy === 1'b0, "R6 done one cycle", {done, busy}, 0);
    endtask

    initial begin
        #500000;
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge m_clk);
        m_rst_n = 1'b1; s_rst_n = 1'b1;
        @(negedge m_clk);
        // R1 reset state
        check({hs_req, hs_ack, busy, done} === 4'b0, "R1 reset strobes", {hs_req, hs_ack, busy, done}, 0);
        check(rsp_rdata === 8'h00, "R1 reset rdata", rsp_rdata, 0);

        // R3 R4 R9 table walk
        for (int i = 0; i < 9; i++)
            run_cmd(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].exp,
                    VECS[i].wr ? "R9 rdata held over write" : "R4 read data");

        // R7 command while busy is ignored
        @(negedge m_clk);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'h8; cmd_wdata = 8'h11;
        @(negedge m_clk);
        cmd_addr = 4'h9; cmd_wdata = 8'hEE;
        check(busy === 1'b1, "R7 busy during collision", busy, 1);
        @(negedge m_clk);
        cmd_valid = 1'b0;
        for (int n = 0; n < 400 && !done; n++) @(negedge m_clk);
        @(negedge m_clk);
        run_cmd(1'b0, 4'h9, 8'h00, 8'h77, "R7 ignored command left reg");
        run_cmd(1'b0, 4'h8, 8'h00, 8'h11, "R3 written word read back");

        check(interlock_bad == 0, "R5 R6 strobe interlock", interlock_bad, 0);

        // R8 out-of-window address is never acknowledged
        @(negedge m_clk);
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 4'h3;
        @(negedge m_clk);
        cmd_valid = 1'b0;
        repeat (60) @(negedge m_clk);
        check(hs_req === 1'b1 && hs_ack === 1'b0 && busy === 1'b1, "R8 no ack outside window",
              {hs_req, hs_ack, busy}, 3'b101);

        // R1 recovery by reset
        m_rst_n = 1'b0; s_rst_n = 1'b0;
        repeat (2) @(negedge m_clk);
        m_rst_n = 1'b1; s_rst_n = 1'b1;
        @(negedge m_clk);
        check({hs_req, hs_ack, busy, done} === 4'b0, "R1 after second reset", {hs_req, hs_ack, busy, done}, 0);
        check(rsp_rdata === 8'h00, "R1 rdata after second reset", rsp_rdata, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule